// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an asynchronous static RAM. It accepts one request at a time, a read or a write of a single word, through a valid/ready handshake. It then plays out the control waveforms the memory needs: an active-low and an active-high chip enable, an output enable, a write enable, a held address, and a shared data bus that it drives only during writes. A read returns its word through a one-clock response strobe.

Each wait is a count of clock cycles. The count is derived at elaboration time from the memory's nanosecond minimums and the clock period parameter `CLK_NS`, rounded up, and is never less than one cycle. A write pulse is the window in which write enable and both chip enables are active together. The controller always ends a write by raising write enable first, with the chip enables and the data driver kept on through that edge. Every access finishes with a turnaround gap in which the memory is deselected and nobody drives the bus. The gap covers the memory's output release time, so write data never meets read data left on the bus.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready`=1, `sram_ce_n`=1, `sram_ce`=0, `sram_oe_n`=1, `sram_we_n`=1 and `rsp_valid`=0.
- R2: Wait counts are ceil(limit_ns / CLK_NS), with a floor of 1. The read count RD is the largest of the 45 ns cycle, 45 ns address access, 45 ns enable access and 22 ns output-enable access counts. At CLK_NS=4 this gives RD=12, and at CLK_NS=10 it gives RD=5.
- R3: A read holds `sram_oe_n` low and both chip enables active for exactly RD cycles, with `sram_addr` equal to the accepted address. `rsp_rdata` returns the word the memory drove in the last of those cycles.
- R4: A write holds `sram_we_n` low for exactly WE = max(ceil(35/CLK_NS), ceil(25/CLK_NS), ceil(45/CLK_NS)-1) cycles, which is 11 at CLK_NS=4. During this window both enables are active, `sram_dq` carries the accepted data and `sram_addr` carries the accepted address.
- R5: A write ends with one cycle in which `sram_we_n` is high while the chip enables stay active and `sram_dq` still carries the write data. The enables go inactive in the following cycle.
- R6: After every access the memory is deselected for exactly GAP = ceil(18/CLK_NS) cycles (5 at CLK_NS=4) before `req_ready` returns high.
- R7: `req_ready` is low from the cycle after acceptance until the access completes. Request inputs are ignored while busy, and address and data are taken only at acceptance.
- R8: `sram_oe_n` and `sram_we_n` are never low together. Write enable is low only while both chip enables are active and the bus is driven. The two chip enables always switch together.
- R9: `rsp_valid` pulses for exactly one clock per read, in the first cycle with `sram_oe_n` high, and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-clock read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_dq | inout | DATA_W | Shared data bus |

## Verification
The hardest case to reach from the ports is a request that arrives while the controller is busy. A request whose fields change in mid-access is just as hard. Neither can happen with a host that waits politely. The bench therefore keeps `req_valid` high throughout every access, and right after acceptance it flips the request to the opposite kind, the complemented address and the complemented data. A design that took the stray request, or that used live inputs instead of the latched ones, would corrupt the memory model or move the address. The sweeps over all sixteen addresses with two arithmetic patterns then expose that corruption.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    // Memory timing minimums in nanoseconds
    localparam int unsigned RD_CYCLE_NS      = 45;
    localparam int unsigned ADDR_ACCESS_NS   = 45;
    localparam int unsigned CE_ACCESS_NS     = 45;
    localparam int unsigned OE_ACCESS_NS     = 22;
    localparam int unsigned BUS_RELEASE_NS   = 18;
    localparam int unsigned WR_CYCLE_NS      = 45;
    localparam int unsigned WE_PULSE_NS      = 35;
    localparam int unsigned WR_ADDR_SETUP_NS = 35;
    localparam int unsigned WR_CE_SETUP_NS   = 35;
    localparam int unsigned WR_DATA_SETUP_NS = 25;

    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2,
        ST_WEND  = 3'd3,
        ST_GAP   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic ce;
        logic oe_n;
        logic we_n;
        logic drive;
    } sram_pins_t;

    function automatic sram_pins_t pins_for(input seq_state_e s);
        sram_pins_t p;
        p.ce_n  = 1'b1;
        p.ce    = 1'b0;
        p.oe_n  = 1'b1;
        p.we_n  = 1'b1;
        p.drive = 1'b0;
        case (s)
            ST_READ: begin
                p.ce_n = 1'b0;
                p.ce   = 1'b1;
                p.oe_n = 1'b0;
            end
            ST_WRITE: begin
                p.ce_n  = 1'b0;
                p.ce    = 1'b1;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
            end
            ST_WEND: begin
                p.ce_n  = 1'b0;
                p.ce    = 1'b1;
                p.drive = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned RD_CYC  = 5,
    parameter int unsigned WE_CYC  = 4,
    parameter int unsigned GAP_CYC = 2,
    parameter int          CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_write,
    input  logic             expired,
    output seq_state_e       state,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output sram_pins_t       pins
);

    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LOAD  = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC - 1);

    seq_state_e nxt;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (start_write) begin
                        nxt      = ST_WRITE;
                        load_val = WE_LOAD;
                    end else begin
                        nxt      = ST_READ;
                        load_val = RD_LOAD;
                    end
                end
            end
            ST_READ: begin
                if (expired) begin
                    nxt      = ST_GAP;
                    load     = 1'b1;
                    load_val = GAP_LOAD;
                end
            end
            ST_WRITE: begin
                if (expired) nxt = ST_WEND;
            end
            ST_WEND: begin
                nxt      = ST_GAP;
                load     = 1'b1;
                load_val = GAP_LOAD;
            end
            ST_GAP: begin
                if (expired) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign pins = pins_for(state);

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= sample;
            if (sample) rdata <= bus_in;
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_NS = 10,
    parameter int          ADDR_W = 18,
    parameter int          DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_ce,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    inout  wire  [DATA_W-1:0] sram_dq
);

    localparam int unsigned RD_CYC = max_u(
        max_u(ns_to_cycles(ADDR_ACCESS_NS, CLK_NS), ns_to_cycles(CE_ACCESS_NS, CLK_NS)),
        max_u(ns_to_cycles(OE_ACCESS_NS, CLK_NS),   ns_to_cycles(RD_CYCLE_NS, CLK_NS)));
    localparam int unsigned WE_CYC = max_u(
        max_u(ns_to_cycles(WE_PULSE_NS, CLK_NS), ns_to_cycles(WR_DATA_SETUP_NS, CLK_NS)),
        max_u(max_u(ns_to_cycles(WR_ADDR_SETUP_NS, CLK_NS), ns_to_cycles(WR_CE_SETUP_NS, CLK_NS)),
              ns_to_cycles(WR_CYCLE_NS, CLK_NS) - 1));
    localparam int unsigned GAP_CYC = ns_to_cycles(BUS_RELEASE_NS, CLK_NS);
    localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WE_CYC), GAP_CYC);
    localparam int          CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e        state;
    sram_pins_t        pins;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              sample_rd;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_ctl_seq #(
        .RD_CYC  (RD_CYC),
        .WE_CYC  (WE_CYC),
        .GAP_CYC (GAP_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_write (req_write),
        .expired     (tmr_expired),
        .state       (state),
        .load        (tmr_load),
        .load_val    (tmr_val),
        .pins        (pins)
    );

    assign sample_rd = (state == ST_READ) && tmr_expired;

    sram_ctl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk    (clk),
        .rst    (rst),
        .sample (sample_rd),
        .bus_in (sram_dq),
        .rdata  (rsp_rdata),
        .rvalid (rsp_valid)
    );

    assign sram_addr = addr_q;
    assign sram_ce_n = pins.ce_n;
    assign sram_ce   = pins.ce;
    assign sram_oe_n = pins.oe_n;
    assign sram_we_n = pins.we_n;
    assign sram_dq   = pins.drive ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int unsigned RD_CYC  = 5,
    parameter int unsigned WE_CYC  = 4,
    parameter int unsigned GAP_CYC = 2,
    parameter int          ADDR_W  = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              ce_n,
    input logic              ce,
    input logic              oe_n,
    input logic              we_n,
    input logic              drive,
    input logic [ADDR_W-1:0] addr
);

    logic [15:0] oe_run;
    logic [15:0] we_run;
    logic [15:0] idle_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_run   <= '0;
            we_run   <= '0;
            idle_run <= 16'(GAP_CYC);
        end else begin
            oe_run   <= oe_n ? '0 : oe_run + 1'b1;
            we_run   <= we_n ? '0 : we_run + 1'b1;
            if (!ce_n)                      idle_run <= '0;
            else if (idle_run < 16'(GAP_CYC)) idle_run <= idle_run + 1'b1;
        end
    end

    assert_read_len_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |-> (oe_run == 16'(RD_CYC)));

    assert_we_len_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_run == 16'(WE_CYC)));

    assert_we_end_held_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (!ce_n && drive));

    assert_deselect_after_end_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |=> ce_n);

    assert_gap_before_select_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_n) |-> (idle_run >= 16'(GAP_CYC)));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

    assert_oe_we_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));

    assert_we_needs_enables_R8: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!ce_n && ce && drive));

    assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (rst)
        drive |-> oe_n);

    assert_enables_paired_R8: assert property (@(posedge clk) disable iff (rst)
        ce_n == !ce);

    assert_rvalid_at_oe_rise_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $rose(oe_n));

    assert_rvalid_single_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

bind sram_ctrl sram_ctrl_chk #(
    .RD_CYC  (RD_CYC),
    .WE_CYC  (WE_CYC),
    .GAP_CYC (GAP_CYC),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ce_n      (sram_ce_n),
    .ce        (sram_ce),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .drive     (pins.drive),
    .addr      (sram_addr)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

    localparam int T  = 4;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NW = 1 << AW;

    localparam int C45 = (45 + T - 1) / T;
    localparam int C35 = (35 + T - 1) / T;
    localparam int C25 = (25 + T - 1) / T;
    localparam int C22 = (22 + T - 1) / T;
    localparam int E_RD  = (C45 > C22) ? C45 : C22;
    localparam int E_WA  = (C35 > C25) ? C35 : C25;
    localparam int E_WE  = (E_WA > C45 - 1) ? E_WA : C45 - 1;
    localparam int E_GAP = (18 + T - 1) / T;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic          req_valid, req_ready, req_write, rsp_valid;
    logic [AW-1:0] req_addr, sram_addr;
    logic [DW-1:0] req_wdata, rsp_rdata;
    logic          sram_ce_n, sram_ce, sram_oe_n, sram_we_n;
    wire  [DW-1:0] sram_dq;

    logic [DW-1:0] mem [NW];
    logic          armed = 1'b0;

    int checks = 0;
    int errors = 0;

    sram_ctrl #(.CLK_NS(T), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq(sram_dq)
    );

    // Memory model: drives on read select, stores at the write-terminating edge
    assign sram_dq = (armed && !sram_ce_n && sram_ce && !sram_oe_n && sram_we_n)
                     ? mem[sram_addr] : {DW{1'bz}};

    always @(posedge sram_we_n) begin
        if (armed && !sram_ce_n && sram_ce) mem[sram_addr] <= sram_dq;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 37 + 11 * k + 5) ^ (k * 8'h5a));
    endfunction

    task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd);
        int n_oe, n_we, n_sel, n_gap, n_rv, n;
        logic prev_oe_n;
        n_oe = 0; n_we = 0; n_sel = 0; n_gap = 0; n_rv = 0; n = 0;
        prev_oe_n = 1'b1;
        rd = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        // stray request held while busy, with every field flipped
        req_write = !w; req_addr = ~a; req_wdata = ~d;
        forever begin
            @(negedge clk);
            if (req_ready) begin
                req_valid = 1'b0;
                break;
            end
            n++;
            if (!sram_oe_n) n_oe++;
            if (!sram_we_n) begin
                n_we++;
                check(sram_dq === d, "R4 write data on bus", int'(sram_dq), int'(d));
            end
            if (!sram_ce_n) begin
                n_sel++;
                check(sram_addr == a, "R7 latched address", int'(sram_addr), int'(a));
                if (w && sram_we_n && sram_oe_n) begin
                    check(sram_dq === d, "R5 data held at write end", int'(sram_dq), int'(d));
                    check(n_we == E_WE, "R5 end follows full pulse", n_we, E_WE);
                end
            end else begin
                n_gap++;
            end
            check(!(!sram_oe_n && !sram_we_n), "R8 oe/we overlap", 1, 0);
            check(sram_ce == !sram_ce_n, "R8 enable pairing", int'(sram_ce), int'(!sram_ce_n));
            if (rsp_valid) begin
                n_rv++;
                rd = rsp_rdata;
                check(sram_oe_n && !prev_oe_n, "R9 strobe at oe release", int'(sram_oe_n), 1);
            end
            prev_oe_n = sram_oe_n;
        end
        if (w) begin
            check(n_we == E_WE, "R4 write pulse length", n_we, E_WE);
            check(n_sel == E_WE + 1, "R5 selected cycles", n_sel, E_WE + 1);
            check(n_oe == 0, "R8 no oe on write", n_oe, 0);
            check(n_rv == 0, "R9 no strobe on write", n_rv, 0);
        end else begin
            check(n_oe == E_RD, "R2 read wait", n_oe, E_RD);
            check(n_sel == E_RD, "R3 read select length", n_sel, E_RD);
            check(n_we == 0, "R8 no we on read", n_we, 0);
            check(n_rv == 1, "R9 one strobe per read", n_rv, 1);
        end
        check(n_gap == E_GAP, "R6 turnaround gap", n_gap, E_GAP);
        check(n == n_sel + n_gap, "R7 busy span", n, n_sel + n_gap);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] got;
        for (int i = 0; i < NW; i++) mem[i] = '0;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        check(sram_ce_n && !sram_ce, "R1 deselected in reset", int'(sram_ce_n), 1);
        check(sram_oe_n && sram_we_n, "R1 strobes high in reset", int'(sram_oe_n & sram_we_n), 1);
        check(!rsp_valid, "R1 no strobe in reset", int'(rsp_valid), 0);
        rst = 1'b0;
        armed = 1'b1;
        @(negedge clk);
        check(req_ready && sram_ce_n && sram_oe_n && sram_we_n, "R1 idle after reset",
              int'(req_ready), 1);

        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < NW; i++) begin
                int a;
                a = (k == 0) ? i : NW - 1 - i;
                access(1'b1, AW'(a), pat(a, k), got);
            end
            for (int i = 0; i < NW; i++) begin
                access(1'b0, AW'(i), '0, got);
                check(got == pat(i, k), "R3 read data", int'(got), int'(pat(i, k)));
            end
        end

        // read-after-read and write-after-read on one address
        access(1'b0, AW'(7), '0, got);
        check(got == pat(7, 1), "R3 repeated read", int'(got), int'(pat(7, 1)));
        access(1'b1, AW'(7), 8'hc3, got);
        access(1'b0, AW'(7), '0, got);
        check(got == 8'hc3, "R3 read after overwrite", int'(got), 32'hc3);
        access(1'b0, AW'(8), '0, got);
        check(got == pat(8, 1), "R7 stray request ignored", int'(got), int'(pat(8, 1)));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule